// File: doc/BRIEF.md
# Cascadable Vectored Interrupt Controller

This controller sits between up to sixteen level-sensitive peripheral request lines and a processor core that has only two interrupt inputs, a normal request (IRQ) and a fast request (FIQ). Each slot is routed to one of the two. Among the enabled slots routed to IRQ, it picks the highest-priority one, where slot 0 ranks highest. It places that slot's handler address in a vector register and raises `irq_o`. Slots routed to FIQ skip the vector machinery: they drive `fiq_o` and show up in a FIQ status register.

Software uses the vector register to mark when service starts and ends. Reading it acknowledges the presented slot. That sets the slot's in-service bit, and the set bit masks every request at the same or lower priority. Writing any value to it ends the service of the highest-priority in-service level and makes the controller choose a new vector. Because the in-service state is a bit vector, higher-priority requests can still interrupt an acknowledged handler, so handlers can nest.

Two instances can be chained. The downstream instance's `irq_o` and `vec_o` feed the upstream instance's `chain_req_i` and `chain_vec_i`. The upstream instance treats them as slot `CHAIN_SLOT`, whose vector comes from the downstream instance. Only the upstream `irq_o` goes to the core.

The control is a four-state machine. Its transitions are as follows.

- IDLE:
  - It goes to PRESENT when an unmasked request appears.
  - It goes to RELOAD on a vector write.
- PRESENT:
  - It goes to ACKED on a vector read.
  - It goes to IDLE when the request goes away.
  - It goes to RELOAD on a vector write.
- ACKED:
  - It goes to PRESENT when a new unmasked request arrives (nesting).
  - It goes to RELOAD on a vector write.
  - It goes to RELOAD when the in-service vector has emptied.
- RELOAD:
  - It goes to PRESENT when a request is pending.
  - Otherwise it goes to IDLE.

Top module: `vic_ctrl`

Register addresses (word index on `bus_addr`):

| Address | Register |
|---|---|
| 0 | vector |
| 1 | default vector |
| 2 | enable bits |
| 3 | FIQ-select bits |
| 4 | FIQ status (read only) |
| 5 | in-service bits (read only) |
| 16+i | handler address of slot i |

## Requirements
- R1: The IRQ winner is the enabled, IRQ-routed, unmasked request with the lowest slot index. One clock after the request is seen, `irq_o` is 1 and `vec_o` holds that slot's handler register (address 16+i).
- R2: `irq_o` stays 1 while any unmasked IRQ request remains. One clock after the last one drops, `irq_o` is 0 and `vec_o` shows the default vector.
- R3: A read of address 0 while `irq_o` is 1 returns the presented vector and sets in-service bit i of the presented slot (readable at address 5). `irq_o` is 0 the next clock. Requests at slot i or any higher index then stay masked. A read of address 0 while `irq_o` is 0 changes nothing.
- R4: A write to address 0 ignores its data. `vec_o` keeps its value in the clock after the write and never takes the written data.
- R5: A write to address 0 clears the lowest-index set in-service bit. Two clocks after the write, `vec_o` shows the next unmasked winner, or the default vector when there is none. A request that is still high raises `irq_o` again.
- R6: The default vector is programmable at address 1. `vec_o` shows it whenever no unmasked IRQ request is pending outside an acknowledged state. It resets to 0.
- R7: While a slot is acknowledged, a request of a lower index raises `irq_o` again with its own vector. Acknowledging it adds its in-service bit.
- R8: A slot whose enable bit (address 2, bit i) is 0 affects neither `irq_o`, `fiq_o` nor `vec_o`.
- R9: A slot whose FIQ-select bit (address 3, bit i) is 1 never reaches the vector logic. It drives `fiq_o` one clock later with no bus access. Address 4 reads back request AND enable AND FIQ-select.
- R10: The request of slot `CHAIN_SLOT` is `req_i` bit `CHAIN_SLOT` OR `chain_req_i`, and its vector is `chain_vec_i`. Its in-service bit clears by itself once `chain_req_i` falls. A chained source is acknowledged by reading both controllers and is ended by writing only the downstream one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (6) | Register word address |
| bus_wdata | input | VW (32) | Write data |
| bus_rdata | output | VW (32) | Read data, combinational from the address |
| req_i | input | NSRC (16) | Level-sensitive peripheral requests |
| chain_req_i | input | 1 | Request from a downstream controller |
| chain_vec_i | input | VW (32) | Vector from a downstream controller |
| irq_o | output | 1 | Normal interrupt request (chain request output when downstream) |
| fiq_o | output | 1 | Fast interrupt request |
| vec_o | output | VW (32) | Current vector register (chain vector output when downstream) |

## Verification
The two functions that can fall in the same cycle are the acknowledge of the presented slot and the arrival of a higher-priority request. The bench provokes this by raising slot 1 in the same cycle as the vector read that acknowledges slot 9. The read must return and mark slot 9 (in-service readback shows bit 9 only). `irq_o` must then drop for one clock and come back carrying slot 1's vector. A second overlap is tested in the chain: the downstream acknowledge drops `chain_req_i` while the upstream instance holds the chain slot in service. The upstream instance must release that bit without any write and settle on its default vector.

// File: rtl/vic_pkg.sv
package vic_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PRESENT = 2'd1,
        ST_ACKED   = 2'd2,
        ST_RELOAD  = 2'd3
    } vic_state_e;

    localparam int A_VEC   = 0;
    localparam int A_DEF   = 1;
    localparam int A_EN    = 2;
    localparam int A_FSEL  = 3;
    localparam int A_FSTAT = 4;
    localparam int A_INSV  = 5;
    localparam int A_HBASE = 16;

endpackage

// File: rtl/vic_regs.sv
module vic_regs
    import vic_pkg::*;
#(
    parameter int NSRC       = 16,
    parameter int VW         = 32,
    parameter int AW         = 6,
    parameter int CHAIN_SLOT = NSRC - 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [AW-1:0]            addr,
    input  logic [VW-1:0]            wdata,
    input  logic [VW-1:0]            chain_vec_i,
    output logic [NSRC-1:0]          en_q,
    output logic [NSRC-1:0]          fsel_q,
    output logic [VW-1:0]            def_q,
    output logic [NSRC-1:0][VW-1:0]  hand_q,
    output logic [NSRC-1:0][VW-1:0]  slot_vec
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            fsel_q <= '0;
            def_q  <= '0;
        end else if (wr_en) begin
            if (addr == AW'(A_EN))   en_q   <= wdata[NSRC-1:0];
            if (addr == AW'(A_FSEL)) fsel_q <= wdata[NSRC-1:0];
            if (addr == AW'(A_DEF))  def_q  <= wdata;
        end
    end

    // One handler register per slot; the chain slot takes its vector from the chain input.
    for (genvar i = 0; i < NSRC; i++) begin : g_slot
        logic [VW-1:0] h_r;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                h_r <= '0;
            else if (wr_en && addr == AW'(A_HBASE + i))
                h_r <= wdata;
        end
        assign hand_q[i] = h_r;
        if (i == CHAIN_SLOT) begin : g_chain
            assign slot_vec[i] = chain_vec_i;
        end else begin : g_local
            assign slot_vec[i] = h_r;
        end
    end

endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
    parameter int NSRC = 16,
    parameter int IW   = $clog2(NSRC)
) (
    input  logic [NSRC-1:0] req,
    input  logic [NSRC-1:0] insv,
    output logic            found,
    output logic [IW-1:0]   idx
);

    logic masked;

    // Slot 0 is the highest priority; any in-service bit at or above a slot masks it.
    always_comb begin
        found  = 1'b0;
        idx    = '0;
        masked = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            masked = masked | insv[i];
            if (!found && req[i] && !masked) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
    import vic_pkg::*;
#(
    parameter int NSRC       = 16,
    parameter int VW         = 32,
    parameter int AW         = 6,
    parameter int CHAIN_SLOT = NSRC - 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_en,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [VW-1:0]   bus_wdata,
    output logic [VW-1:0]   bus_rdata,
    input  logic [NSRC-1:0] req_i,
    input  logic            chain_req_i,
    input  logic [VW-1:0]   chain_vec_i,
    output logic            irq_o,
    output logic            fiq_o,
    output logic [VW-1:0]   vec_o
);

    localparam int IW = $clog2(NSRC);

    vic_state_e state_q, state_d;

    logic [NSRC-1:0]          en_q, fsel_q, insv_q, insv_d;
    logic [VW-1:0]            def_q, vec_q;
    logic [NSRC-1:0][VW-1:0]  hand_q, slot_vec;
    logic [NSRC-1:0]          req_eff, irq_req, fiq_stat;
    logic                     found, fiq_q, rd_vec, wr_vec, ack, load, cleared;
    logic [IW-1:0]            win_idx, win_q;
    logic [AW-1:0]            hoff;
    logic                     hsel_ok;

    assign req_eff  = req_i | (NSRC'(chain_req_i) << CHAIN_SLOT);
    assign irq_req  = req_eff & en_q & ~fsel_q;
    assign fiq_stat = req_eff & en_q & fsel_q;
    assign rd_vec   = bus_en && !bus_we && bus_addr == AW'(A_VEC);
    assign wr_vec   = bus_en &&  bus_we && bus_addr == AW'(A_VEC);
    assign ack      = rd_vec && state_q == ST_PRESENT;

    vic_regs #(.NSRC(NSRC), .VW(VW), .AW(AW), .CHAIN_SLOT(CHAIN_SLOT)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (bus_en && bus_we),
        .addr        (bus_addr),
        .wdata       (bus_wdata),
        .chain_vec_i (chain_vec_i),
        .en_q        (en_q),
        .fsel_q      (fsel_q),
        .def_q       (def_q),
        .hand_q      (hand_q),
        .slot_vec    (slot_vec)
    );

    vic_prio #(.NSRC(NSRC), .IW(IW)) u_prio (
        .req   (irq_req),
        .insv  (insv_q),
        .found (found),
        .idx   (win_idx)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_vec)     state_d = ST_RELOAD;
                else if (found) state_d = ST_PRESENT;
            end
            ST_PRESENT: begin
                if (wr_vec)      state_d = ST_RELOAD;
                else if (rd_vec) state_d = ST_ACKED;
                else if (!found) state_d = ST_IDLE;
            end
            ST_ACKED: begin
                if (wr_vec)              state_d = ST_RELOAD;
                else if (found)          state_d = ST_PRESENT;
                else if (insv_q == '0)   state_d = ST_RELOAD;
            end
            ST_RELOAD: begin
                if (wr_vec)     state_d = ST_RELOAD;
                else if (found) state_d = ST_PRESENT;
                else            state_d = ST_IDLE;
            end
        endcase
    end

    // In-service update: acknowledge sets, completion clears the highest level,
    // the chain level releases when the downstream request falls.
    always_comb begin
        insv_d  = insv_q;
        cleared = 1'b0;
        if (ack) begin
            insv_d[win_q] = 1'b1;
        end else if (wr_vec) begin
            for (int i = 0; i < NSRC; i++) begin
                if (!cleared && insv_q[i]) begin
                    insv_d[i] = 1'b0;
                    cleared   = 1'b1;
                end
            end
        end
        if (insv_q[CHAIN_SLOT] && !chain_req_i && !(ack && win_q == IW'(CHAIN_SLOT)))
            insv_d[CHAIN_SLOT] = 1'b0;
    end

    assign load = !wr_vec && !ack && (state_q != ST_ACKED || found);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q  <= '0;
            win_q  <= '0;
            insv_q <= '0;
            fiq_q  <= 1'b0;
        end else begin
            insv_q <= insv_d;
            fiq_q  <= |fiq_stat;
            if (load) begin
                vec_q <= found ? slot_vec[win_idx] : def_q;
                win_q <= found ? win_idx : win_q;
            end
        end
    end

    assign irq_o = (state_q == ST_PRESENT);
    assign fiq_o = fiq_q;
    assign vec_o = vec_q;

    // Register read port
    assign hoff    = bus_addr - AW'(A_HBASE);
    assign hsel_ok = (bus_addr >= AW'(A_HBASE)) && (hoff < AW'(NSRC));

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            AW'(A_VEC):   bus_rdata = vec_q;
            AW'(A_DEF):   bus_rdata = def_q;
            AW'(A_EN):    bus_rdata = VW'(en_q);
            AW'(A_FSEL):  bus_rdata = VW'(fsel_q);
            AW'(A_FSTAT): bus_rdata = VW'(fiq_stat);
            AW'(A_INSV):  bus_rdata = VW'(insv_q);
            default:      if (hsel_ok) bus_rdata = hand_q[hoff[IW-1:0]];
        endcase
    end

    // R2: IRQ only follows a cycle in which an IRQ-routed request was pending
    p_irq_has_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(|irq_req));

    // R3: acknowledge marks the presented slot in service
    p_ack_marks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> insv_q[$past(win_q)]);

    // R3: acknowledge removes the request from the core
    p_ack_drops_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !irq_o);

    // R4: completion write never changes the vector in the following cycle
    p_wr_keeps_vec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_vec |=> $stable(vec_q));

    // R5: in-service state changes only through vector reads and writes while the chain is up
    p_insv_bus_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_vec && !wr_vec && chain_req_i) |=> $stable(insv_q));

    // R9: fast request output only follows an asserting FIQ source
    p_fiq_has_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> $past(|fiq_stat));

endmodule

// File: tb/vic_ctrl_tb.sv
module vic_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] DEFV = 32'hDEF0_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        up_en = 1'b0, dn_en = 1'b0, bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] up_rdata, dn_rdata, up_vec, dn_vec;
    logic [15:0] up_req = '0, dn_req = '0;
    logic        up_irq, up_fiq, dn_irq, dn_fiq;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vic_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_en(up_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(up_rdata),
        .req_i(up_req), .chain_req_i(dn_irq), .chain_vec_i(dn_vec),
        .irq_o(up_irq), .fiq_o(up_fiq), .vec_o(up_vec)
    );

    vic_ctrl dn_i (
        .clk(clk), .rst_n(rst_n), .bus_en(dn_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(dn_rdata),
        .req_i(dn_req), .chain_req_i(1'b0), .chain_vec_i(32'h0),
        .irq_o(dn_irq), .fiq_o(dn_fiq), .vec_o(dn_vec)
    );

    function automatic logic [31:0] hv(input int i);
        return 32'hA000_0000 + 32'(i * 16);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_rd(input bit dn, input int a, output logic [31:0] d);
        @(negedge clk);
        if (dn) dn_en = 1'b1; else up_en = 1'b1;
        bus_we = 1'b0;
        bus_addr = 6'(a);
        #1 d = dn ? dn_rdata : up_rdata;
        @(negedge clk);
        up_en = 1'b0; dn_en = 1'b0;
    endtask

    task automatic bus_wr(input bit dn, input int a, input logic [31:0] v);
        @(negedge clk);
        if (dn) dn_en = 1'b1; else up_en = 1'b1;
        bus_we = 1'b1;
        bus_addr = 6'(a);
        bus_wdata = v;
        @(negedge clk);
        up_en = 1'b0; dn_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R6 reset irq", 32'(up_irq), 0);
        chk("R6 reset fiq", 32'(up_fiq), 0);
        chk("R6 reset vec", up_vec, 0);
        bus_rd(0, 5, d);
        chk("R3 reset in-service", d, 0);
    endtask

    task automatic t_setup();
        for (int i = 0; i < 16; i++) begin
            bus_wr(0, 16 + i, hv(i));
            bus_wr(1, 16 + i, hv(i) | 32'h0100_0000);
        end
        bus_wr(0, 1, DEFV);
        bus_wr(1, 1, DEFV);
        bus_wr(0, 2, 32'h0000_FFFF);
        bus_wr(1, 2, 32'h0000_FFFF);
        @(negedge clk);
        chk("R6 default shown", up_vec, DEFV);
    endtask

    task automatic t_basic();
        @(negedge clk); up_req[5] = 1'b1; up_req[9] = 1'b1;
        @(negedge clk);
        chk("R1 irq raised", 32'(up_irq), 1);
        chk("R1 winner vector", up_vec, hv(5));
    endtask

    task automatic t_ack();
        logic [31:0] d;
        bus_rd(0, 0, d);
        chk("R3 read returns vector", d, hv(5));
        chk("R3 irq drops after ack", 32'(up_irq), 0);
        bus_rd(0, 5, d);
        chk("R3 in-service bit", d, 32'h20);
        up_req[7] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R3 lower masked", 32'(up_irq), 0);
        bus_rd(0, 0, d);
        bus_rd(0, 5, d);
        chk("R3 idle read no effect", d, 32'h20);
    endtask

    task automatic t_nest();
        logic [31:0] d;
        up_req[2] = 1'b1;
        @(negedge clk);
        chk("R7 nested irq", 32'(up_irq), 1);
        chk("R7 nested vector", up_vec, hv(2));
        bus_rd(0, 0, d);
        bus_rd(0, 5, d);
        chk("R7 nested in-service", d, 32'h24);
    endtask

    task automatic t_end();
        logic [31:0] d;
        up_req[2] = 1'b0;
        bus_wr(0, 0, 32'h1234_5678);
        chk("R4 vec held after write", up_vec, hv(2));
        @(negedge clk);
        chk("R4 data not stored", up_vec, DEFV);
        chk("R5 still masked", 32'(up_irq), 0);
        bus_rd(0, 5, d);
        chk("R5 highest level cleared", d, 32'h20);
        bus_wr(0, 0, 32'h0);
        @(negedge clk);
        chk("R5 level re-raise", 32'(up_irq), 1);
        chk("R5 next winner", up_vec, hv(5));
    endtask

    task automatic t_idle();
        up_req = '0;
        @(negedge clk);
        chk("R2 irq drops", 32'(up_irq), 0);
        chk("R2 default vector", up_vec, DEFV);
    endtask

    task automatic t_disable();
        bus_wr(0, 2, 32'h0000_FFEF);
        up_req[4] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 disabled irq", 32'(up_irq), 0);
        chk("R8 disabled fiq", 32'(up_fiq), 0);
        chk("R8 disabled vec", up_vec, DEFV);
        up_req[4] = 1'b0;
        bus_wr(0, 2, 32'h0000_FFFF);
    endtask

    task automatic t_fiq();
        logic [31:0] d;
        bus_wr(0, 3, 32'h40);
        up_req[6] = 1'b1;
        @(negedge clk);
        chk("R9 fiq raised", 32'(up_fiq), 1);
        chk("R9 no irq", 32'(up_irq), 0);
        chk("R9 vec untouched", up_vec, DEFV);
        bus_rd(0, 4, d);
        chk("R9 fiq status", d, 32'h40);
        up_req[6] = 1'b0;
        @(negedge clk);
        chk("R9 fiq falls", 32'(up_fiq), 0);
        bus_wr(0, 3, 32'h0);
    endtask

    task automatic t_same_cycle();
        logic [31:0] d;
        up_req[9] = 1'b1;
        @(negedge clk);
        up_en = 1'b1; bus_we = 1'b0; bus_addr = 6'd0;
        up_req[1] = 1'b1;
        #1 d = up_rdata;
        @(negedge clk);
        up_en = 1'b0;
        chk("R3 read during preempt", d, hv(9));
        chk("R3 gap after ack", 32'(up_irq), 0);
        @(negedge clk);
        chk("R7 preempt irq", 32'(up_irq), 1);
        chk("R7 preempt vector", up_vec, hv(1));
        bus_rd(0, 0, d);
        up_req[1] = 1'b0;
        bus_rd(0, 5, d);
        chk("R7 both in service", d, 32'h202);
        bus_wr(0, 0, 32'h0);
        up_req[9] = 1'b0;
        bus_wr(0, 0, 32'h0);
        @(negedge clk);
        bus_rd(0, 5, d);
        chk("R5 all released", d, 0);
    endtask

    task automatic t_chain();
        logic [31:0] d;
        dn_req[3] = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 chain irq upstream", 32'(up_irq), 1);
        chk("R10 chain vector", up_vec, hv(3) | 32'h0100_0000);
        bus_rd(0, 0, d);
        chk("R10 upstream read", d, hv(3) | 32'h0100_0000);
        chk("R10 chain masked", 32'(up_irq), 0);
        bus_rd(1, 0, d);
        chk("R10 downstream read", d, hv(3) | 32'h0100_0000);
        repeat (3) @(negedge clk);
        chk("R10 upstream quiet", 32'(up_irq), 0);
        chk("R10 upstream default", up_vec, DEFV);
        bus_rd(0, 5, d);
        chk("R10 chain level auto-release", d, 0);
        dn_req[3] = 1'b0;
        bus_wr(1, 0, 32'h0);
        repeat (3) @(negedge clk);
        bus_rd(1, 5, d);
        chk("R10 downstream released", d, 0);
        chk("R10 no re-raise", 32'(up_irq), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_setup();
        t_basic();
        t_ack();
        t_nest();
        t_end();
        t_idle();
        t_disable();
        t_fiq();
        t_same_cycle();
        t_chain();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule